// File: doc/BRIEF.md
# Cascadable Wide Phase Accumulator

This block is the phase accumulator of a numerically controlled oscillator. It holds a 48-bit running phase. On every rising clock edge it adds a frequency word and a single carry-in bit to that phase. The 13 top bits of the phase go to a phase-to-amplitude stage that sits outside this block.

For finer frequency steps, two copies can be chained into one 96-bit accumulator. The lower copy's registered carry-out drives the upper copy's carry-in. The upper copy is built with its increment path delayed by one cycle (parameter `INC_LAG = 1`). This keeps its increment aligned with the carry it receives, so its phase is the top half of the 96-bit sum one cycle later.

A synchronous reset clears the phase. Any copies that share a clock and are reset on the same edge therefore hold a fixed phase relationship afterwards.

Top module: `nco_phase_acc`

## Requirements
- R1: While `rst` is high at a rising edge, that edge clears `accValue` and `carryOut` to 0, and also clears every stage of the delayed increment path. The first edge after release therefore adds an increment of zero when `INC_LAG` is 1.
- R2: At each rising edge without reset, `accValue` becomes the old `accValue` plus the effective increment plus `carryIn`, modulo 2^48. The effective increment is `incWord` when `INC_LAG` is 0.
- R3: With `carryIn` = 1, the step is exactly one larger than with `carryIn` = 0 for the same increment. With a zero increment, the phase advances by one per edge.
- R4: The sum wraps modulo 2^48 and never saturates. An increment of all ones with `carryIn` = 1 leaves `accValue` unchanged and sets `carryOut`.
- R5: `carryOut` is the carry out of bit 47 of the same addition that updates `accValue`, registered on the same edge. It is visible from the following cycle.
- R6: `phaseWord` equals bits 47 down to 35 of `accValue`, with bit 12 of `phaseWord` taken from bit 47.
- R7: With `INC_LAG` = 1, each addition uses the `incWord` value sampled at the previous rising edge.
- R8: A lower copy (`INC_LAG` = 0) whose `carryOut` feeds an upper copy (`INC_LAG` = 1) forms a 96-bit accumulator. The upper `accValue` equals bits 95:48 of the 96-bit sum of the previous cycle. The upper `carryOut` is the 96-bit overflow, delayed by one further cycle.
- R9: Reset is synchronous. Raising `rst` between edges does not change `accValue` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| incWord | input | ACC_W (48) | Frequency (phase increment) word |
| carryIn | input | 1 | Adds one to the effective increment; driven by a lower stage's carryOut when chained |
| accValue | output | ACC_W (48) | Current accumulated phase |
| phaseWord | output | PHASE_W (13) | Top phase bits sent to the amplitude stage |
| carryOut | output | 1 | Registered carry from the top accumulator bit |

## Verification
The hardest case to reach is an overflow of the full 96-bit chain. For it, the lower half must carry on the same step that the upper half sits near its wrap point, and the upper carry then appears two cycles after the step that caused it. Small increments would take on the order of 2^48 cycles to get there. The stimulus therefore loads increments close to all ones in both halves, with `carryIn` set, so that both halves overflow on nearly every cycle. It then switches to increments that move the upper half slowly, so the lower half carries on only some steps. A mid-run reset that is raised between edges shows the reset taking effect only at the clock edge.

// File: rtl/nco_phase_acc_pkg.sv
package nco_phase_acc_pkg;

  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic clear;  // zero all state on this edge
    logic step;   // perform one accumulation on this edge
  } accStrobe_t;

endpackage

// File: rtl/nco_phase_acc_ctrl.sv
module nco_phase_acc_ctrl
  import nco_phase_acc_pkg::*;
(
  input  logic       rst,
  output accStrobe_t strobes
);

  // Reset has priority; otherwise the accumulator advances on every edge.
  always_comb begin
    strobes.clear = rst;
    strobes.step  = ~rst;
  end

endmodule

// File: rtl/nco_phase_acc_incpath.sv
module nco_phase_acc_incpath
  import nco_phase_acc_pkg::*;
#(
  parameter int ACC_W   = 48,
  parameter int INC_LAG = 0
) (
  input  logic             clk,
  input  accStrobe_t       strobes,
  input  logic [ACC_W-1:0] incWord,
  output logic [ACC_W-1:0] effInc
);

  generate
    if (INC_LAG == 0) begin : g_direct
      assign effInc = incWord;
    end else begin : g_delayed
      logic [ACC_W-1:0] lagStage [INC_LAG];
      for (genvar i = 0; i < INC_LAG; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (strobes.clear) begin
            lagStage[i] <= '0;
          end else if (i == 0) begin
            lagStage[i] <= incWord;
          end else begin
            lagStage[i] <= lagStage[(i > 0) ? i - 1 : 0];
          end
        end
      end
      assign effInc = lagStage[INC_LAG-1];
    end
  endgenerate

endmodule

// File: rtl/nco_phase_acc_dp.sv
module nco_phase_acc_dp
  import nco_phase_acc_pkg::*;
#(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  accStrobe_t       strobes,
  input  logic [ACC_W-1:0] effInc,
  input  logic             carryIn,
  output logic [ACC_W-1:0] accQ,
  output logic             carryQ
);

  localparam int SUM_W = ACC_W + 1;

  logic [SUM_W-1:0] sumNext;

  always_comb begin
    sumNext = {1'b0, accQ} + {1'b0, effInc} + {{ACC_W{1'b0}}, carryIn};
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      accQ   <= '0;
      carryQ <= 1'b0;
    end else if (strobes.step) begin
      accQ   <= sumNext[ACC_W-1:0];
      carryQ <= sumNext[ACC_W];
    end
  end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_phase_acc_pkg::*;
#(
  parameter int ACC_W   = 48,
  parameter int PHASE_W = 13,
  parameter int INC_LAG = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ACC_W-1:0]   incWord,
  input  logic               carryIn,
  output logic [ACC_W-1:0]   accValue,
  output logic [PHASE_W-1:0] phaseWord,
  output logic               carryOut
);

  localparam int PHASE_LO = ACC_W - PHASE_W;

  accStrobe_t       strobes;
  logic [ACC_W-1:0] effInc;

  nco_phase_acc_ctrl u_ctrl (
    .rst     (rst),
    .strobes (strobes)
  );

  nco_phase_acc_incpath #(
    .ACC_W   (ACC_W),
    .INC_LAG (INC_LAG)
  ) u_incpath (
    .clk     (clk),
    .strobes (strobes),
    .incWord (incWord),
    .effInc  (effInc)
  );

  nco_phase_acc_dp #(
    .ACC_W (ACC_W)
  ) u_dp (
    .clk     (clk),
    .strobes (strobes),
    .effInc  (effInc),
    .carryIn (carryIn),
    .accQ    (accValue),
    .carryQ  (carryOut)
  );

  assign phaseWord = accValue[ACC_W-1:PHASE_LO];

endmodule

// File: rtl/nco_phase_acc_chk.sv
module nco_phase_acc_chk #(
  parameter int ACC_W   = 48,
  parameter int INC_LAG = 0
) (
  input logic             clk,
  input logic             rst,
  input logic [ACC_W-1:0] incWord,
  input logic             carryIn,
  input logic [ACC_W-1:0] effInc,
  input logic [ACC_W-1:0] accValue,
  input logic             carryOut
);

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= armed | rst;

  // R1: the first edge after a reset edge sees cleared state
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(rst)) |-> (accValue == '0 && !carryOut && effInc == ((INC_LAG == 0) ? incWord : '0)));

  // R2 and R5: sum and carry together follow from the previous operands
  p_step_sum_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && !rst) |=> ({carryOut, accValue} ==
      ({1'b0, $past(accValue)} + {1'b0, $past(effInc)} + {{ACC_W{1'b0}}, $past(carryIn)})));

  // R4 and R5: a carry means the phase wrapped, no carry means it did not move backwards
  p_wrap_order_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && !rst) |=> (carryOut ? (accValue <= $past(accValue)) : (accValue >= $past(accValue))));

  generate
    if (INC_LAG == 1) begin : g_lag
      // R7: the increment used lags the port by one edge
      p_inc_lag_r7: assert property (@(posedge clk) disable iff (rst)
        (armed && !rst) |=> (effInc == $past(incWord)));
    end else begin : g_nolag
      // R2: with no lag the port value is used directly
      p_inc_direct_r2: assert property (@(posedge clk) disable iff (rst)
        armed |-> (effInc == incWord));
    end
  endgenerate

endmodule

bind nco_phase_acc nco_phase_acc_chk #(
  .ACC_W   (ACC_W),
  .INC_LAG (INC_LAG)
) uChk (
  .clk      (clk),
  .rst      (rst),
  .incWord  (incWord),
  .carryIn  (carryIn),
  .effInc   (effInc),
  .accValue (accValue),
  .carryOut (carryOut)
);

// File: tb/sim_nco_phase_acc.sv
module sim_nco_phase_acc;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst = 1'b1;
  logic [47:0] incH = '0;
  logic [47:0] incL = '0;
  logic        cin  = 1'b0;

  logic [47:0] accL, accH;
  logic [12:0] phL, phH;
  logic        coL, coH;

  nco_phase_acc #(.INC_LAG(0)) u0 (
    .clk(clk), .rst(rst), .incWord(incL), .carryIn(cin),
    .accValue(accL), .phaseWord(phL), .carryOut(coL)
  );

  nco_phase_acc #(.INC_LAG(1)) u1 (
    .clk(clk), .rst(rst), .incWord(incH), .carryIn(coL),
    .accValue(accH), .phaseWord(phH), .carryOut(coH)
  );

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  // Behavioural 96-bit reference
  logic [95:0] total = '0;
  logic [95:0] prevTotal = '0;
  logic        ovfPrev = 1'b0;
  logic        expLowCarry = 1'b0;
  logic        expUpCarry = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run(input logic [47:0] h, input logic [47:0] l, input logic c, input string tag);
    logic [96:0] sum97;
    logic [48:0] lowSum;
    incH = h; incL = l; cin = c;
    @(posedge clk);
    if (rst) begin
      total = '0; prevTotal = '0; ovfPrev = 1'b0;
      expLowCarry = 1'b0; expUpCarry = 1'b0;
    end else begin
      sum97  = {1'b0, total} + {1'b0, h, l} + {96'd0, c};
      lowSum = {1'b0, total[47:0]} + {1'b0, l} + {48'd0, c};
      expLowCarry = lowSum[48];
      prevTotal   = total;
      total       = sum97[95:0];
      expUpCarry  = ovfPrev;
      ovfPrev     = sum97[96];
    end
    @(negedge clk);
    check(rst ? "R1" : tag, {16'd0, accL}, {16'd0, total[47:0]});
    check("R5", {63'd0, coL}, {63'd0, expLowCarry});
    check("R7 R8", {16'd0, accH}, {16'd0, prevTotal[95:48]});
    check("R6", {51'd0, phH}, {51'd0, prevTotal[95:83]});
    check("R6", {51'd0, phL}, {51'd0, total[47:35]});
    check("R8", {63'd0, coH}, {63'd0, expUpCarry});
  endtask

  initial begin
    @(negedge clk);
    // R1: reset held for several edges
    rst = 1'b1;
    for (int i = 0; i < 3; i++) run(48'h1234, 48'h5678, 1'b1, "R1");
    rst = 1'b0;
    // R2: plain accumulation
    for (int i = 0; i < 10; i++) run(48'd5, 48'h0001_2345_6789, 1'b0, "R2");
    // R3: carry-in only, zero increment
    for (int i = 0; i < 10; i++) run(48'd0, 48'd0, 1'(i % 2), "R3");
    // R4: all ones plus carry-in wraps to the same value every step
    for (int i = 0; i < 8; i++) run(48'hFFFF_FFFF_FFFF, 48'hFFFF_FFFF_FFFF, 1'b1, "R4");
    // R4/R8: upper half close to its wrap, lower carrying on some steps
    for (int i = 0; i < 20; i++) run(48'hFFFF_FFFF_FFF0, 48'h8000_0000_0001, 1'b0, "R4");
    for (int i = 0; i < 12; i++) run(48'h7FFF_FFFF_FFFF, 48'hC000_0000_0000, 1'b1, "R4");
    // R2/R7: increments changing every cycle
    for (int i = 0; i < 40; i++)
      run({$urandom(), 16'($urandom())}, {$urandom(), 16'(1 + i)}, 1'($urandom() % 2), "R2");
    // R9: reset raised between edges has no effect before the next edge
    rst = 1'b1;
    #3;
    check("R9", {16'd0, accL}, {16'd0, total[47:0]});
    check("R9", {16'd0, accH}, {16'd0, prevTotal[95:48]});
    run(48'hAAAA, 48'hBBBB, 1'b1, "R1");
    run(48'hAAAA, 48'hBBBB, 1'b1, "R1");
    rst = 1'b0;
    // R7: first step after reset uses a cleared lagged increment
    for (int i = 0; i < 6; i++) run(48'h0000_0100_0000 + 48'(i), 48'hF000_0000_0000, 1'b0, "R2");
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule